// File: doc/BRIEF.md
# Endpoint Buffer-Ready Status Tracker

This block keeps one "buffer ready" flag per endpoint and per direction for a USB device controller with thirteen endpoints. Software asks for an endpoint to be made ready by writing a prime bitmask. Each requested bit waits in a pending set until an internal sequencer accepts it. The flag rises only after that acceptance, so it is never set in the same cycle as the write. Requests are accepted one at a time, so a write that raises many bits takes longer than a write that raises one. Accepts also slow down while the bus is reported busy.

A ready flag can be cleared in three ways: a USB bus reset, a per-bit clear from the DMA engine, or a software flush bitmask. A flush or bus reset also cancels any prime still waiting for that bit. While the DMA engine is retiring a transfer descriptor for an endpoint, that endpoint's flag reads as zero. The underlying flag is kept, so it shows again once retirement ends. The result is a read-only 32-bit status word. Each accept is also signalled to the DMA side as a one-cycle strobe.

Top module: `ep_ready_tracker`

## Requirements
- R1: After rst_n is released, status_o and accept_o are all zero.
- R2: Receive-ready for endpoint n (0 to 12) is status bit n, and transmit-ready for endpoint n is status bit 16+n. Bits 13-15 and 29-31 always read zero. The same bit positions apply to prime_mask, flush_mask, dma_clear, retire_start, retire_done and accept_o.
- R3: A prime bit is captured at the rising edge that samples prime_wr. With ACCEPT_CYC = A and traffic_busy low, the bit's status rises at the (A+1)-th rising edge after the capturing edge, and not before.
- R4: Pending primes are accepted one at a time, lowest bit position first, and each accept takes A+1 cycles. accept_o holds at most one bit and pulses for exactly the cycle before the status bit rises.
- R5: Each cycle in which traffic_busy is high while an accept is in progress delays that accept by one cycle.
- R6: A dma_clear bit clears the matching ready flag at the next edge. If a dma_clear bit and an accept of the same bit fall in the same cycle, the clear wins and the flag stays 0.
- R7: A flush write clears exactly the ready flags whose flush_mask bit is 1 and leaves every other flag unchanged.
- R8: A bus_reset cycle clears every ready flag, every pending prime and every retirement mask at the next edge.
- R9: A flush or bus reset that covers a bit with a prime still pending or in progress cancels that prime, so the flag stays 0.
- R10: From the edge that samples a retire_start bit until the edge that samples the matching retire_done bit, that status bit reads 0. Afterwards the flag shows again unless it was cleared in the meantime.
- R11: Prime or flush bits written at the reserved positions (13-15 and 29-31) have no effect on status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset; clears all flags and pending primes |
| prime_wr | input | 1 | Prime write strobe |
| prime_mask | input | 32 | Prime bitmask |
| flush_wr | input | 1 | Flush write strobe |
| flush_mask | input | 32 | Flush bitmask |
| traffic_busy | input | 1 | Bus traffic busy; stalls the accept countdown |
| dma_clear | input | 32 | Per-bit clear from the DMA engine |
| retire_start | input | 32 | Per-bit start of descriptor retirement |
| retire_done | input | 32 | Per-bit end of descriptor retirement |
| accept_o | output | 32 | One-cycle strobe of the accepted prime bit |
| status_o | output | 32 | Read-only ready status word |

## Verification
The two functions that can meet in one cycle are the sequencer's accept of a bit and a DMA clear of the same bit. The bench primes a single bit and counts the A+1 edges to the accept cycle. In that cycle it confirms that accept_o carries the bit and drives dma_clear for the same bit. It then judges the outcome at the next edge: the status bit must stay 0 and must not reappear later. A second collision, a flush that lands while a prime is still being served, is provoked two cycles after the prime and must leave the flag at 0.

// File: rtl/ep_ready_pkg.sv
package ep_ready_pkg;
  localparam int STAT_W = 32;
  localparam int HALF_W = 16;

  // Mask of implemented bit positions for num_ep endpoints per half.
  function automatic logic [STAT_W-1:0] impl_mask(input int num_ep);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (i < num_ep) begin
        m[i]          = 1'b1;
        m[i + HALF_W] = 1'b1;
      end
    end
    return m;
  endfunction

  // Isolate the lowest set bit (fixed ascending priority).
  function automatic logic [STAT_W-1:0] lowest_one(input logic [STAT_W-1:0] x);
    return x & (~x + 1'b1);
  endfunction
endpackage

// File: rtl/ep_cmd_mask.sv
module ep_cmd_mask
  import ep_ready_pkg::*;
#(
  parameter int NUM_EP = 13
) (
  input  logic              bus_reset,
  input  logic              prime_wr,
  input  logic [STAT_W-1:0] prime_mask,
  input  logic              flush_wr,
  input  logic [STAT_W-1:0] flush_mask,
  input  logic [STAT_W-1:0] dma_clear,
  input  logic [STAT_W-1:0] retire_start,
  input  logic [STAT_W-1:0] retire_done,
  output logic [STAT_W-1:0] prime_set,
  output logic [STAT_W-1:0] kill,
  output logic [STAT_W-1:0] clr_set,
  output logic [STAT_W-1:0] ret_on,
  output logic [STAT_W-1:0] ret_off
);
  localparam logic [STAT_W-1:0] VALID = impl_mask(NUM_EP);

  always_comb begin
    prime_set = prime_wr ? (prime_mask & VALID) : '0;
    if (bus_reset)     kill = VALID;
    else if (flush_wr) kill = flush_mask & VALID;
    else               kill = '0;
    clr_set = dma_clear & VALID;
    ret_on  = retire_start & VALID;
    ret_off = bus_reset ? VALID : (retire_done & VALID);
  end
endmodule

// File: rtl/ep_prime_seq.sv
module ep_prime_seq
  import ep_ready_pkg::*;
#(
  parameter int ACCEPT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] prime_set,
  input  logic [STAT_W-1:0] kill,
  input  logic              hold,
  output logic [STAT_W-1:0] accept
);
  localparam int CNT_W = (ACCEPT_CYC < 2) ? 1 : $clog2(ACCEPT_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCEPT_CYC - 1);

  logic [STAT_W-1:0] pend_q, cur_q, live;
  logic              serving_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              abort_ev, fire_ev;

  assign live     = pend_q & ~kill;
  assign abort_ev = serving_q && ((kill & cur_q) != '0);
  assign fire_ev  = serving_q && !abort_ev && !hold && (cnt_q == '0);
  assign accept   = fire_ev ? cur_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cur_q     <= '0;
      serving_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      pend_q <= (pend_q | prime_set) & ~kill & ~accept;
      if (serving_q) begin
        if (abort_ev || fire_ev) serving_q <= 1'b0;
        else if (!hold)          cnt_q     <= cnt_q - 1'b1;
      end else if (live != '0) begin
        serving_q <= 1'b1;
        cur_q     <= lowest_one(live);
        cnt_q     <= CNT_LOAD;
      end
    end
  end

  // R4
  accept_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept));

  // R9
  cancel_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (accept == '0));

  // R5
  busy_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serving_q && hold && !abort_ev) |=> (serving_q && $stable(cnt_q)));
endmodule

// File: rtl/ep_ready_flags.sv
module ep_ready_flags
  import ep_ready_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] accept,
  input  logic [STAT_W-1:0] clr_set,
  input  logic [STAT_W-1:0] kill,
  input  logic [STAT_W-1:0] ret_on,
  input  logic [STAT_W-1:0] ret_off,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] rdy_q, ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      ret_q <= '0;
    end else begin
      rdy_q <= (rdy_q | accept) & ~(clr_set | kill);
      ret_q <= (ret_q & ~ret_off) | ret_on;
    end
  end

  assign status = rdy_q & ~ret_q;

  // R3
  rdy_only_via_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept == '0) |=> ((rdy_q & ~$past(rdy_q)) == '0));

  // R6
  clear_beats_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept & clr_set) != '0) |=> ((rdy_q & $past(accept & clr_set)) == '0));

  // R10
  retire_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_on != '0) |=> ((status & $past(ret_on)) == '0));
endmodule

// File: rtl/ep_ready_tracker.sv
module ep_ready_tracker
  import ep_ready_pkg::*;
#(
  parameter int NUM_EP     = 13,
  parameter int ACCEPT_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        prime_wr,
  input  logic [31:0] prime_mask,
  input  logic        flush_wr,
  input  logic [31:0] flush_mask,
  input  logic        traffic_busy,
  input  logic [31:0] dma_clear,
  input  logic [31:0] retire_start,
  input  logic [31:0] retire_done,
  output logic [31:0] accept_o,
  output logic [31:0] status_o
);
  localparam logic [STAT_W-1:0] VALID = impl_mask(NUM_EP);

  logic [STAT_W-1:0] prime_set, kill, clr_set, ret_on, ret_off;

  ep_cmd_mask #(.NUM_EP(NUM_EP)) u_mask (
    .bus_reset(bus_reset), .prime_wr(prime_wr), .prime_mask(prime_mask),
    .flush_wr(flush_wr), .flush_mask(flush_mask), .dma_clear(dma_clear),
    .retire_start(retire_start), .retire_done(retire_done),
    .prime_set(prime_set), .kill(kill), .clr_set(clr_set),
    .ret_on(ret_on), .ret_off(ret_off)
  );

  ep_prime_seq #(.ACCEPT_CYC(ACCEPT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .prime_set(prime_set), .kill(kill),
    .hold(traffic_busy), .accept(accept_o)
  );

  ep_ready_flags u_flags (
    .clk(clk), .rst_n(rst_n), .accept(accept_o), .clr_set(clr_set),
    .kill(kill), .ret_on(ret_on), .ret_off(ret_off), .status(status_o)
  );

  // R8
  bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (status_o == '0));

  // R2
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o | accept_o) & ~VALID) == '0);

  // R3
  no_same_cycle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_wr && accept_o == '0) |=> ((status_o & ~$past(status_o)) == '0));
endmodule

// File: tb/ep_ready_tracker_tb.sv
module ep_ready_tracker_tb;
  localparam int A = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        prime_wr = 1'b0;
  logic [31:0] prime_mask = '0;
  logic        flush_wr = 1'b0;
  logic [31:0] flush_mask = '0;
  logic        traffic_busy = 1'b0;
  logic [31:0] dma_clear = '0;
  logic [31:0] retire_start = '0;
  logic [31:0] retire_done = '0;
  logic [31:0] accept_o, status_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ep_ready_tracker #(.NUM_EP(13), .ACCEPT_CYC(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .prime_wr(prime_wr),
    .prime_mask(prime_mask), .flush_wr(flush_wr), .flush_mask(flush_mask),
    .traffic_busy(traffic_busy), .dma_clear(dma_clear),
    .retire_start(retire_start), .retire_done(retire_done),
    .accept_o(accept_o), .status_o(status_o)
  );

  // prime mask, flush mask, expected status afterwards
  localparam int NV = 8;
  localparam logic [95:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},  // R2 rx ep0
    {32'h0001_0000, 32'h0000_0000, 32'h0001_0001},  // R2 tx ep0
    {32'hE000_E000, 32'h0000_0000, 32'h0001_0001},  // R11 reserved prime
    {32'h0000_0000, 32'h0000_0001, 32'h0001_0000},  // R7 partial flush
    {32'h1FFF_1FFF, 32'h0000_0000, 32'h1FFF_1FFF},  // R2 R4 all endpoints
    {32'h0000_0000, 32'hFFFF_0000, 32'h0000_1FFF},  // R7 flush tx half
    {32'h0000_0000, 32'hE000_E000, 32'h0000_1FFF},  // R11 reserved flush
    {32'h0000_0000, 32'h0000_1FFF, 32'h0000_0000}   // R7 flush rx half
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_prime(input logic [31:0] m);
    prime_wr = 1'b1; prime_mask = m;
    tick();
    prime_wr = 1'b0; prime_mask = '0;
  endtask

  task automatic do_flush(input logic [31:0] m);
    flush_wr = 1'b1; flush_mask = m;
    tick();
    flush_wr = 1'b0; flush_mask = '0;
  endtask

  task automatic do_bus_reset();
    bus_reset = 1'b1;
    tick();
    bus_reset = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    check("R1 status", status_o, 32'h0);
    check("R1 accept", accept_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_prime(VEC[i][95:64]);
      repeat (120) tick();
      do_flush(VEC[i][63:32]);
      check($sformatf("R2/R7/R11 vector %0d", i), status_o, VEC[i][31:0]);
    end

    // R3 exact latency
    do_bus_reset();
    do_prime(32'h0000_0004);
    repeat (A) tick();
    check("R3 not yet ready", status_o, 32'h0);
    check("R4 accept strobe", accept_o, 32'h0000_0004);
    tick();
    check("R3 ready at A+1", status_o, 32'h0000_0004);
    check("R4 strobe ends", accept_o, 32'h0);

    // R4 ordering
    do_bus_reset();
    do_prime(32'h0001_0002);
    repeat (A + 1) tick();
    check("R4 lowest first", status_o, 32'h0000_0002);
    repeat (A) tick();
    check("R4 second pending", status_o, 32'h0000_0002);
    tick();
    check("R4 second ready", status_o, 32'h0001_0002);

    // R5 traffic stall
    do_bus_reset();
    do_prime(32'h0000_0001);
    tick();
    traffic_busy = 1'b1;
    repeat (5) tick();
    traffic_busy = 1'b0;
    repeat (2) tick();
    check("R5 stalled", status_o, 32'h0);
    tick();
    check("R5 ready after stall", status_o, 32'h0000_0001);

    // R6 clear collides with accept
    do_bus_reset();
    do_prime(32'h0000_0008);
    repeat (A) tick();
    check("R6 accept cycle", accept_o, 32'h0000_0008);
    dma_clear = 32'h0000_0008;
    tick();
    dma_clear = '0;
    check("R6 clear wins", status_o, 32'h0);
    repeat (10) tick();
    check("R6 stays clear", status_o, 32'h0);

    // R6 plain clear
    do_prime(32'h0000_0010);
    repeat (A + 1) tick();
    check("R6 set before clear", status_o, 32'h0000_0010);
    dma_clear = 32'h0000_0010;
    tick();
    dma_clear = '0;
    check("R6 dma clear", status_o, 32'h0);

    // R9 flush cancels pending
    do_bus_reset();
    do_prime(32'h0000_0006);
    do_flush(32'h0000_0004);
    repeat (20) tick();
    check("R9 flush cancels pending", status_o, 32'h0000_0002);

    // R9 flush cancels in-progress
    do_bus_reset();
    do_prime(32'h0000_0001);
    repeat (2) tick();
    do_flush(32'h0000_0001);
    repeat (20) tick();
    check("R9 flush aborts serving", status_o, 32'h0);

    // R9 bus reset cancels pending
    do_prime(32'h0000_0001);
    do_bus_reset();
    repeat (20) tick();
    check("R9 bus reset cancels", status_o, 32'h0);

    // R8 bus reset clears ready
    do_prime(32'h0001_0001);
    repeat (20) tick();
    check("R8 set before reset", status_o, 32'h0001_0001);
    do_bus_reset();
    check("R8 bus reset clears", status_o, 32'h0);

    // R10 retirement mask
    do_prime(32'h0000_0020);
    repeat (A + 1) tick();
    check("R10 ready", status_o, 32'h0000_0020);
    retire_start = 32'h0000_0020;
    tick();
    retire_start = '0;
    check("R10 hidden", status_o, 32'h0);
    repeat (3) tick();
    check("R10 still hidden", status_o, 32'h0);
    retire_done = 32'h0000_0020;
    tick();
    retire_done = '0;
    check("R10 visible again", status_o, 32'h0000_0020);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule